// File: doc/BRIEF.md
# Signed Multiply Divide Unit

This block is a sequential arithmetic engine for 16-bit two's-complement words. It performs one of two operations, chosen when a job starts, and the result always lands in a pair of accumulator words, A (low) and B (high), plus an overflow flag. A multiply combines the operand word with A into a signed 32-bit product. A divide takes the 32-bit dividend held in B:A and the operand word as divisor. It returns the signed quotient in A and the signed remainder in B.

Both operations work on magnitudes. The signs are stripped on entry and put back in a final correction cycle. The multiply runs as sixteen add-and-shift steps. The divide runs as sixteen restoring shift-and-subtract steps. The divide checks for overflow before it iterates: the upper half of the dividend magnitude must be smaller than the divisor magnitude. After sign correction it checks a second time, that the quotient carries the sign it should. Operand fetching and address generation sit outside the block. A caller pulses `start` with the inputs valid and then waits for the one-cycle `done` pulse.

Top module: `smd_unit`

## Requirements
- R1: With `op_div`=0 (multiply), A_out/B_out hold the low/high halves of the signed 32-bit product of `a_in` and `opnd`, both sign-extended.
- R2: A multiply always finishes with `ovf`=0, even after an earlier overflowing divide.
- R3: With `op_div`=1 (divide), when no pre-check overflow occurs, A_out holds the quotient of |B:A| by |opnd|. A nonzero quotient is two's-complement negated when the dividend sign (`b_in` bit 15) differs from the divisor sign (`opnd` bit 15). A zero quotient stays zero.
- R4: When no pre-check overflow occurs, B_out holds the remainder magnitude. It is negated when `b_in` bit 15 is 1, so the remainder takes the dividend's sign.
- R5: The dividend magnitude is formed as follows. The low word is negated first. The high word is complemented, with one added only when the negated low word is zero. If that high magnitude is greater than or equal to |opnd|, then `ovf`=1, A_out holds the low magnitude word and B_out holds the high magnitude word.
- R6: A divisor of zero always takes the R5 path and sets `ovf`=1.
- R7: After the sign is applied to a nonzero quotient, `ovf` is set when bit 15 of A_out differs from the expected quotient sign. For example, 0x00008000/1 gives A_out=0x8000 with `ovf`=1, while 0xFFFF8000/1 gives A_out=0x8000 with `ovf`=0.
- R8: `busy` is 1 from the edge that accepts `start` until the result edge. `done` is 1 for exactly one cycle. That cycle follows the 17th rising edge after the accepting edge.
- R9: A `start` that arrives while `busy` is 1 is ignored. It produces no extra result, and the running job's result is unchanged.
- R10: Reset clears `busy`, `done`, A_out, B_out and `ovf`. The outputs hold their last result until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a job when idle |
| op_div | input | 1 | 0 = multiply, 1 = divide |
| opnd | input | 16 | Multiplier or divisor word |
| a_in | input | 16 | A word (multiplicand or dividend low) |
| b_in | input | 16 | B word (dividend high) |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle result strobe |
| a_out | output | 16 | Result A (product low or quotient) |
| b_out | output | 16 | Result B (product high or remainder) |
| ovf | output | 1 | Overflow flag |

## Verification
Multiply runs with the four sign combinations, a zero operand and the most negative value squared. Together these separate a correct sign fix from magnitude-only arithmetic and expose a dropped top product bit. Divide runs with all four sign pairings. This distinguishes quotient sign from remainder sign, and a zero quotient with a negative expected sign shows whether zero is wrongly negated. The overflow cases set a zero divisor, a high word equal to the divisor, and the two 0x8000 quotients of opposite expected sign against each other, which isolates the pre-check from the post-correction sign test. A second start issued mid-job and an idle hold period show that neither touches the outputs.

// File: rtl/smd_pkg.sv
package smd_pkg;
    localparam int DW = 16;
    localparam int CW = $clog2(DW);

    typedef logic [DW-1:0]   word_t;
    typedef logic [2*DW-1:0] dword_t;

    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} state_e;

    typedef struct packed {
        logic  div;      // operation is divide
        logic  neg_q;    // result (product or quotient) must be negated
        logic  neg_r;    // remainder must be negated
        logic  pre_ovf;  // divide failed the high-word check
        word_t arg_mag;  // magnitude of the operand word
    } job_t;

    function automatic word_t neg_w(word_t x);
        return ~x + word_t'(1);
    endfunction

    function automatic word_t abs_w(word_t x);
        return x[DW-1] ? neg_w(x) : x;
    endfunction

    // magnitude of hi:lo; low word negated first, carry into high only on zero
    function automatic dword_t abs_dw(word_t hi, word_t lo);
        word_t nl;
        word_t nh;
        nl = neg_w(lo);
        nh = ~hi + ((nl == '0) ? word_t'(1) : word_t'(0));
        return hi[DW-1] ? {nh, nl} : {hi, lo};
    endfunction
endpackage

// File: rtl/smd_ctrl.sv
module smd_ctrl
    import smd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic load,
    output logic step,
    output logic fin
);
    state_e        st_q;
    logic [CW-1:0] cnt_q;

    assign busy = (st_q != ST_IDLE);
    assign load = (st_q == ST_IDLE) && start;
    assign step = (st_q == ST_RUN);
    assign fin  = (st_q == ST_FIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (start) begin
                    st_q  <= ST_RUN;
                    cnt_q <= '0;
                end
                ST_RUN: begin
                    cnt_q <= cnt_q + CW'(1);
                    if (cnt_q == CW'(DW - 1)) st_q <= ST_FIN;
                end
                ST_FIN:  st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/smd_step.sv
module smd_step
    import smd_pkg::*;
(
    input  logic  is_div,
    input  word_t hi_i,
    input  word_t lo_i,
    input  word_t arg_i,
    output word_t hi_o,
    output word_t lo_o
);
    logic [DW:0] sum;
    logic [DW:0] trial;
    logic        ge;

    always_comb begin
        // multiply: conditional add, then shift the pair right
        sum   = {1'b0, hi_i} + (lo_i[0] ? {1'b0, arg_i} : '0);
        // divide: shift the pair left, trial subtract
        trial = {hi_i, lo_i[DW-1]};
        ge    = (trial >= {1'b0, arg_i});
        if (is_div) begin
            hi_o = ge ? DW'(trial - {1'b0, arg_i}) : trial[DW-1:0];
            lo_o = {lo_i[DW-2:0], ge};
        end else begin
            {hi_o, lo_o} = {sum, lo_i[DW-1:1]};
        end
    end
endmodule

// File: rtl/smd_fix.sv
module smd_fix
    import smd_pkg::*;
(
    input  job_t  job_i,
    input  word_t hi_i,
    input  word_t lo_i,
    output word_t a_o,
    output word_t b_o,
    output logic  ovf_o
);
    dword_t prod;

    always_comb begin
        prod  = job_i.neg_q ? (~{hi_i, lo_i} + dword_t'(1)) : {hi_i, lo_i};
        a_o   = prod[DW-1:0];
        b_o   = prod[2*DW-1:DW];
        ovf_o = 1'b0;
        if (job_i.div) begin
            if (job_i.pre_ovf) begin
                a_o   = lo_i;
                b_o   = hi_i;
                ovf_o = 1'b1;
            end else begin
                a_o = lo_i;
                if (lo_i != '0) begin
                    if (job_i.neg_q) a_o = neg_w(lo_i);
                    if (a_o[DW-1] != job_i.neg_q) ovf_o = 1'b1;
                end
                b_o = job_i.neg_r ? neg_w(hi_i) : hi_i;
            end
        end
    end
endmodule

// File: rtl/smd_unit.sv
module smd_unit
    import smd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        op_div,
    input  logic [15:0] opnd,
    input  logic [15:0] a_in,
    input  logic [15:0] b_in,
    output logic        busy,
    output logic        done,
    output logic [15:0] a_out,
    output logic [15:0] b_out,
    output logic        ovf
);
    logic   load, step, fin;
    job_t   job_q;
    word_t  hi_q, lo_q, hi_n, lo_n;
    word_t  fa, fb;
    logic   fo;
    word_t  a_q, b_q;
    logic   o_q, done_q;
    dword_t dvd_mag;
    word_t  arg_mag;

    smd_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .busy  (busy),
        .load  (load),
        .step  (step),
        .fin   (fin)
    );

    smd_step u_step (
        .is_div (job_q.div),
        .hi_i   (hi_q),
        .lo_i   (lo_q),
        .arg_i  (job_q.arg_mag),
        .hi_o   (hi_n),
        .lo_o   (lo_n)
    );

    smd_fix u_fix (
        .job_i (job_q),
        .hi_i  (hi_q),
        .lo_i  (lo_q),
        .a_o   (fa),
        .b_o   (fb),
        .ovf_o (fo)
    );

    always_comb begin
        dvd_mag = abs_dw(b_in, a_in);
        arg_mag = abs_w(opnd);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            job_q  <= '0;
            hi_q   <= '0;
            lo_q   <= '0;
            a_q    <= '0;
            b_q    <= '0;
            o_q    <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= fin;
            if (load) begin
                job_q.div     <= op_div;
                job_q.arg_mag <= arg_mag;
                job_q.neg_r   <= op_div & b_in[DW-1];
                job_q.neg_q   <= op_div ? (b_in[DW-1] ^ opnd[DW-1])
                                        : (a_in[DW-1] ^ opnd[DW-1]);
                job_q.pre_ovf <= op_div && (dvd_mag[2*DW-1:DW] >= arg_mag);
                hi_q <= op_div ? dvd_mag[2*DW-1:DW] : '0;
                lo_q <= op_div ? dvd_mag[DW-1:0] : abs_w(a_in);
            end else if (step && !(job_q.div && job_q.pre_ovf)) begin
                hi_q <= hi_n;
                lo_q <= lo_n;
            end
            if (fin) begin
                a_q <= fa;
                b_q <= fb;
                o_q <= fo;
            end
        end
    end

    assign done  = done_q;
    assign a_out = a_q;
    assign b_out = b_q;
    assign ovf   = o_q;
endmodule

// File: rtl/smd_unit_chk.sv
module smd_unit_chk
    import smd_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  start,
    input logic  busy,
    input logic  done,
    input logic  ovf,
    input word_t a_out,
    input word_t b_out,
    input logic  job_div,
    input logic  job_neg_r,
    input word_t job_arg
);
    // R8: done lasts one cycle
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: an accepted start raises busy
    a_r8_busy_after_start: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R9: busy only rises because of a start
    a_r9_busy_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    // R10: outputs move only together with done
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable({a_out, b_out, ovf}));

    // R2: multiply never reports overflow
    a_r2_mul_no_ovf: assert property (@(posedge clk) disable iff (rst)
        (done && !job_div) |-> !ovf);

    // R6: zero divisor overflows
    a_r6_zero_div: assert property (@(posedge clk) disable iff (rst)
        (done && job_div && job_arg == '0) |-> ovf);

    // R4: nonzero remainder follows the dividend sign
    a_r4_rem_sign: assert property (@(posedge clk) disable iff (rst)
        (done && job_div && !ovf && b_out != '0) |-> (b_out[DW-1] == job_neg_r));
endmodule

bind smd_unit smd_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .ovf       (ovf),
    .a_out     (a_out),
    .b_out     (b_out),
    .job_div   (job_q.div),
    .job_neg_r (job_q.neg_r),
    .job_arg   (job_q.arg_mag)
);

// File: tb/test_smd_unit.sv
module test_smd_unit;
    localparam int CLK_PERIOD = 10;
    localparam int LAT = 18;

    logic        clk = 1'b0, rst = 1'b1, start = 1'b0, op_div = 1'b0;
    logic [15:0] opnd = '0, a_in = '0, b_in = '0;
    logic        busy, done, ovf;
    logic [15:0] a_out, b_out;

    int n_chk = 0, n_err = 0, cyc = 0;
    logic prev_done = 1'b0;

    typedef struct {
        logic [15:0] a;
        logic [15:0] b;
        logic        o;
        int          t0;
        string       req;
    } exp_t;
    exp_t sb[$];

    smd_unit i_smd_unit (
        .clk(clk), .rst(rst), .start(start), .op_div(op_div), .opnd(opnd),
        .a_in(a_in), .b_in(b_in), .busy(busy), .done(done),
        .a_out(a_out), .b_out(b_out), .ovf(ovf)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(bit ok, string req, string what, longint act, longint expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic exp_t mul_model(logic [15:0] x, logic [15:0] a, string req);
        exp_t   e;
        longint p;
        p     = longint'($signed(a)) * longint'($signed(x));
        e.a   = p[15:0];
        e.b   = p[31:16];
        e.o   = 1'b0;
        e.req = req;
        e.t0  = 0;
        return e;
    endfunction

    function automatic exp_t div_model(logic [15:0] x, logic [15:0] a, logic [15:0] b, string req);
        exp_t   e;
        longint dv, dm, hi, lo, dsm, q, r;
        logic   qs;
        dv  = longint'($signed({b, a}));
        dm  = (dv < 0) ? -dv : dv;
        hi  = (dm >> 16) & 64'hFFFF;
        lo  = dm & 64'hFFFF;
        dsm = x[15] ? (65536 - longint'(x)) : longint'(x);
        qs  = b[15] ^ x[15];
        e.req = req;
        e.t0  = 0;
        if (hi >= dsm) begin
            e.a = lo[15:0];
            e.b = hi[15:0];
            e.o = 1'b1;
        end else begin
            q   = dm / dsm;
            r   = dm % dsm;
            e.a = q[15:0];
            e.o = 1'b0;
            if (q != 0) begin
                if (qs) e.a = 16'((65536 - q) & 64'hFFFF);
                if (e.a[15] != qs) e.o = 1'b1;
            end
            e.b = b[15] ? 16'((65536 - r) & 64'hFFFF) : r[15:0];
        end
        return e;
    endfunction

    // driver: called at a falling edge
    task automatic issue(logic d, logic [15:0] x, logic [15:0] a, logic [15:0] b, string req);
        exp_t e;
        e    = d ? div_model(x, a, b, req) : mul_model(x, a, req);
        e.t0 = cyc;
        sb.push_back(e);
        op_div = d; opnd = x; a_in = a; b_in = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // monitor: compare every result against the scoreboard head
    always @(negedge clk) begin
        exp_t e;
        if (!rst) begin
            if (done && prev_done) chk(1'b0, "R8", "done longer than one cycle", 1, 0);
            if (done) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R9", "unexpected done", 1, 0);
                end else begin
                    e = sb.pop_front();
                    chk({a_out, b_out, ovf} == {e.a, e.b, e.o}, e.req, "A/B/OVF",
                        {a_out, b_out, ovf}, {e.a, e.b, e.o});
                    chk(cyc - e.t0 == LAT, "R8", "latency", cyc - e.t0, LAT);
                end
            end
            prev_done <= done;
        end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
    end

    initial begin
        exp_t        e;
        logic [15:0] ha, hb;
        logic        ho;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk({busy, done, a_out, b_out, ovf} == '0, "R10", "reset state",
            {busy, done, a_out, b_out, ovf}, 0);

        // R1 multiply sign combinations and extremes
        issue(1'b0, 16'd5,      16'd3,      16'h0, "R1");
        issue(1'b0, 16'd5,      16'hFFFD,   16'h0, "R1");
        issue(1'b0, 16'hFFF9,   16'h1234,   16'h0, "R1");
        issue(1'b0, 16'hFFF9,   16'hFFFD,   16'h0, "R1");
        issue(1'b0, 16'h8000,   16'h8000,   16'h0, "R1");
        issue(1'b0, 16'h0,      16'h7FFF,   16'h0, "R1");
        issue(1'b0, 16'h7FFF,   16'h8000,   16'h0, "R1");

        // R3/R4 divide sign pairings
        issue(1'b1, 16'd7,      16'd100,    16'h0,    "R3");
        issue(1'b1, 16'd7,      16'hFF9C,   16'hFFFF, "R4");
        issue(1'b1, 16'hFFF9,   16'd100,    16'h0,    "R3");
        issue(1'b1, 16'hFFF9,   16'hFF9C,   16'hFFFF, "R4");
        issue(1'b1, 16'd1000,   16'h5678,   16'h0123, "R3");
        issue(1'b1, 16'd100,    16'hFFFB,   16'hFFFF, "R3 zero quotient");

        // R5/R6 pre-check overflow
        issue(1'b1, 16'd1,      16'h0,      16'hFFFE, "R5");
        issue(1'b1, 16'd5,      16'h0,      16'h0005, "R5");
        issue(1'b1, 16'h0,      16'd44,     16'h0,    "R6");
        // R2 multiply after overflow clears flag
        issue(1'b0, 16'd2,      16'd2,      16'h0,    "R2");
        chk(ovf == 1'b0, "R2", "ovf after multiply", ovf, 0);

        // R7 post-correction sign test
        issue(1'b1, 16'd1,      16'h8000,   16'h0000, "R7");
        issue(1'b1, 16'd1,      16'h8000,   16'hFFFF, "R7");
        issue(1'b1, 16'hFFFF,   16'h8000,   16'h0000, "R7");

        // R8/R9 start while busy is ignored
        e    = div_model(16'd9, 16'd200, 16'h0, "R9");
        e.t0 = cyc;
        sb.push_back(e);
        op_div = 1'b1; opnd = 16'd9; a_in = 16'd200; b_in = 16'h0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        chk(busy == 1'b1, "R8", "busy mid-job", busy, 1);
        op_div = 1'b0; opnd = 16'd3; a_in = 16'd3; start = 1'b1;
        repeat (2) @(negedge clk);
        start = 1'b0;
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
        chk(busy == 1'b0, "R8", "busy after done", busy, 0);

        // R10 hold with idle inputs changing
        ha = a_out; hb = b_out; ho = ovf;
        opnd = 16'hAAAA; a_in = 16'h5555; b_in = 16'h1111;
        repeat (25) @(negedge clk);
        chk({a_out, b_out, ovf} == {ha, hb, ho}, "R10", "outputs hold",
            {a_out, b_out, ovf}, {ha, hb, ho});
        summary();
    end
endmodule